// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits behind the bus pins of a word-wide, single-supply flash device and turns the host's bus-write traffic into operation requests. A host unlocks a command by writing fixed codes to two fixed "magic" addresses. After the unlock prefix, a final code picks the operation. The block emits a one-cycle request for word program (with target address and data word), chip erase, block erase, page erase or lockout enable. It also keeps an identification-mode flag and multiplexes the identification words onto the read path while that mode is active.

The bus strobes (active-low chip enable, output enable and write enable) are sampled on the block clock. A write cycle runs from a falling to a rising write-enable edge while chip enable is low and output enable is high. The address is captured at the falling edge and the data at the rising edge. Any read cycle, or any write that does not match the expected step, drops the sequence back to idle. Block and page erases aimed at the boot range are dropped while the lockout is in force. The lockout is in force when the lockout flag is set and the high-voltage override is clear.

The sequence state machine has seven states:
- ST_IDLE, waiting for a first unlock write.
- ST_UNLK1, after the first unlock write.
- ST_UNLK2, after the second unlock write. The third code is chosen here.
- ST_PROG, waiting for the program target.
- ST_ERS1, after the erase setup code.
- ST_ERS2, after the second unlock of the erase prefix.
- ST_ERS3, waiting for the erase or lockout code.

Its transitions are:
- T_UNLOCK: ST_IDLE to ST_UNLK1.
- T_KEY: ST_UNLK1 to ST_UNLK2.
- T_PSETUP: ST_UNLK2 to ST_PROG.
- T_ESETUP: ST_UNLK2 to ST_ERS1.
- T_EUNLK: ST_ERS1 to ST_ERS2.
- T_EKEY: ST_ERS2 to ST_ERS3.
- T_ISSUE: ST_PROG or ST_ERS3 to ST_IDLE, with a request.
- T_IDCMD: ST_UNLK2 to ST_IDLE, entering or leaving ID mode.
- T_ABORT: any state to ST_IDLE on a read cycle or a mismatch.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: The writes AA@5555, 55@2AAA, A0@5555 and then one write of address X and data D cause a single-cycle prog_req with op_addr=X and op_data=D (all 16 bits). X is the address present at the falling write edge, even if the address changes before the rising edge.
- R2: Command matching compares only address bits 14..0 and data bits 7..0. For example, address 0x15555 matches 5555 and data 0xFFAA matches AA.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 cause erase_chip_req. chip_keep_boot is 1 exactly when the lockout is in force (lock_set=1 and hv_override=0).
- R4: The same five-write prefix followed by 30 at address X causes erase_blk_req with op_addr=X. Followed by 50 at address X, it causes erase_page_req with op_addr=X.
- R5: When the lockout is in force and X < 0x2000 (the boot range), the block or page erase of R4 produces no request. While hv_override=1, the erase is issued even with lock_set=1.
- R6: The five-write prefix followed by 40@5555 causes lock_req.
- R7: AA@5555, 55@2AAA, 90@5555 sets id_active. id_active clears with AA@5555, 55@2AAA, F0@5555, or with a single F0 write to any address while id_active=1.
- R8: While id_active=1, rd_data is 0x00DA at address 0, 0x003D at address 1, {15'b0, lock_set} at address 2, and 0 elsewhere. While id_active=0, rd_data equals arr_rdata.
- R9: A read cycle (ce_n=0 and oe_n=0) or a non-matching write during a sequence returns it to ST_IDLE. A later sequence must then start from its first write.
- R10: A write-enable pulse while ce_n=1 or oe_n=0 is not a write cycle and does not advance the sequence.
- R11: While busy=1, completed write cycles are ignored and leave the sequence state unchanged.
- R12: At most one of the five request outputs is high in any cycle, and each request is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data word |
| arr_rdata | input | DATA_W | Array read data for normal reads |
| lock_set | input | 1 | Boot lockout flag from the array |
| hv_override | input | 1 | High-voltage override on the reset pin |
| busy | input | 1 | Operation in progress |
| rd_data | output | DATA_W | Read data (ID words or array data) |
| prog_req | output | 1 | Word program request pulse |
| erase_chip_req | output | 1 | Chip erase request pulse |
| erase_blk_req | output | 1 | Block erase request pulse |
| erase_page_req | output | 1 | Page erase request pulse |
| lock_req | output | 1 | Lockout enable request pulse |
| op_addr | output | ADDR_W | Target address of the last request |
| op_data | output | DATA_W | Data word of the last program request |
| chip_keep_boot | output | 1 | Chip erase must skip the boot range |
| id_active | output | 1 | Identification mode active |

## Verification
The bench builds the block with its defaults: an 18-bit address, a 16-bit word and an 8K-word boot range. The wide address lets a magic address be aliased through bit 16 (0x15555), so the bench can show that bits above 14 are ignored in matching. The boot size puts the lockout edge at 0x1FFF versus 0x2000, so the bench drives erases on both sides of it, with and without the override.

// File: rtl/unlock_cmd_pkg.sv
package unlock_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_PROG,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3
    } seq_state_t;

    localparam int          CMD_AW     = 15;
    localparam int          CMD_DW     = 8;
    localparam logic [14:0] MAGIC_A    = 15'h5555;
    localparam logic [14:0] MAGIC_B    = 15'h2AAA;
    localparam logic [7:0]  K_UNLOCK   = 8'hAA;
    localparam logic [7:0]  K_KEY      = 8'h55;
    localparam logic [7:0]  K_PROG     = 8'hA0;
    localparam logic [7:0]  K_ERASE    = 8'h80;
    localparam logic [7:0]  K_ID_IN    = 8'h90;
    localparam logic [7:0]  K_ID_OUT   = 8'hF0;
    localparam logic [7:0]  K_CHIP     = 8'h10;
    localparam logic [7:0]  K_BLOCK    = 8'h30;
    localparam logic [7:0]  K_PAGE     = 8'h50;
    localparam logic [7:0]  K_LOCK     = 8'h40;

endpackage

// File: rtl/bus_cycle_capture.sv
module bus_cycle_capture #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_cyc
);

    logic              we_q;
    logic              armed;
    logic [ADDR_W-1:0] lat_addr;
    logic              we_fall;
    logic              we_rise;
    logic              wr_gate;

    assign we_fall = we_q && !we_n;
    assign we_rise = !we_q && we_n;
    assign wr_gate = !ce_n && oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            armed    <= 1'b0;
            lat_addr <= '0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            rd_cyc   <= 1'b0;
        end else begin
            we_q   <= we_n;
            rd_cyc <= !ce_n && !oe_n;
            wr_stb <= 1'b0;
            if (we_fall) begin
                armed    <= wr_gate;
                lat_addr <= addr;
            end else if (!wr_gate) begin
                armed <= 1'b0;
            end
            if (we_rise) begin
                wr_stb  <= armed && wr_gate;
                wr_addr <= lat_addr;
                wr_data <= wdata;
                armed   <= 1'b0;
            end
        end
    end

    // R10: a write strobe only follows a gated rising edge
    a_r10_gated_stb: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(!ce_n && oe_n));

    a_r12_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import unlock_cmd_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int BOOT_WORDS = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_cyc,
    input  logic              lock_set,
    input  logic              hv_override,
    input  logic              busy,
    output logic              prog_req,
    output logic              erase_chip_req,
    output logic              erase_blk_req,
    output logic              erase_page_req,
    output logic              lock_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              chip_keep_boot,
    output logic              id_active
);

    localparam logic [ADDR_W-1:0] BOOT_LIMIT = ADDR_W'(BOOT_WORDS);

    seq_state_t        state, st_nx;
    logic              id_nx, keep_nx;
    logic              prog_nx, chip_nx, blk_nx, page_nx, lock_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic [DATA_W-1:0] data_nx;
    logic [CMD_AW-1:0] c_addr;
    logic [CMD_DW-1:0] c_data;
    logic              lock_eff;
    logic              in_boot;

    assign c_addr   = wr_addr[CMD_AW-1:0];
    assign c_data   = wr_data[CMD_DW-1:0];
    assign lock_eff = lock_set && !hv_override;
    assign in_boot  = wr_addr < BOOT_LIMIT;

    function automatic logic hit(input logic [CMD_AW-1:0] a_in,
                                 input logic [CMD_DW-1:0] d_in,
                                 input logic [CMD_AW-1:0] a_ref,
                                 input logic [CMD_DW-1:0] d_ref);
        return (a_in == a_ref) && (d_in == d_ref);
    endfunction

    always_comb begin
        st_nx   = state;
        id_nx   = id_active;
        keep_nx = chip_keep_boot;
        prog_nx = 1'b0;
        chip_nx = 1'b0;
        blk_nx  = 1'b0;
        page_nx = 1'b0;
        lock_nx = 1'b0;
        addr_nx = op_addr;
        data_nx = op_data;
        if (rd_cyc) begin
            st_nx = ST_IDLE;                                   // T_ABORT
        end else if (wr_stb && !busy) begin
            st_nx = ST_IDLE;                                   // T_ABORT unless matched
            unique case (state)
                ST_IDLE: begin
                    if (hit(c_addr, c_data, MAGIC_A, K_UNLOCK))
                        st_nx = ST_UNLK1;                      // T_UNLOCK
                    else if (id_active && c_data == K_ID_OUT)
                        id_nx = 1'b0;
                end
                ST_UNLK1: begin
                    if (hit(c_addr, c_data, MAGIC_B, K_KEY))
                        st_nx = ST_UNLK2;                      // T_KEY
                end
                ST_UNLK2: begin
                    if (hit(c_addr, c_data, MAGIC_A, K_PROG))
                        st_nx = ST_PROG;                       // T_PSETUP
                    else if (hit(c_addr, c_data, MAGIC_A, K_ERASE))
                        st_nx = ST_ERS1;                       // T_ESETUP
                    else if (hit(c_addr, c_data, MAGIC_A, K_ID_IN))
                        id_nx = 1'b1;                          // T_IDCMD
                    else if (hit(c_addr, c_data, MAGIC_A, K_ID_OUT))
                        id_nx = 1'b0;                          // T_IDCMD
                end
                ST_PROG: begin
                    prog_nx = 1'b1;                            // T_ISSUE
                    addr_nx = wr_addr;
                    data_nx = wr_data;
                end
                ST_ERS1: begin
                    if (hit(c_addr, c_data, MAGIC_A, K_UNLOCK))
                        st_nx = ST_ERS2;                       // T_EUNLK
                end
                ST_ERS2: begin
                    if (hit(c_addr, c_data, MAGIC_B, K_KEY))
                        st_nx = ST_ERS3;                       // T_EKEY
                end
                ST_ERS3: begin
                    if (hit(c_addr, c_data, MAGIC_A, K_CHIP)) begin
                        chip_nx = 1'b1;
                        keep_nx = lock_eff;
                    end else if (hit(c_addr, c_data, MAGIC_A, K_LOCK)) begin
                        lock_nx = 1'b1;
                    end else if (c_data == K_BLOCK) begin
                        blk_nx  = !(lock_eff && in_boot);
                        addr_nx = blk_nx ? wr_addr : op_addr;
                    end else if (c_data == K_PAGE) begin
                        page_nx = !(lock_eff && in_boot);
                        addr_nx = page_nx ? wr_addr : op_addr;
                    end
                end
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_req       <= 1'b0;
            erase_chip_req <= 1'b0;
            erase_blk_req  <= 1'b0;
            erase_page_req <= 1'b0;
            lock_req       <= 1'b0;
            op_addr        <= '0;
            op_data        <= '0;
            chip_keep_boot <= 1'b0;
            id_active      <= 1'b0;
        end else begin
            prog_req       <= prog_nx;
            erase_chip_req <= chip_nx;
            erase_blk_req  <= blk_nx;
            erase_page_req <= page_nx;
            lock_req       <= lock_nx;
            op_addr        <= addr_nx;
            op_data        <= data_nx;
            chip_keep_boot <= keep_nx;
            id_active      <= id_nx;
        end
    end

    // R12: requests are exclusive and single-cycle
    a_r12_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_chip_req, erase_blk_req, erase_page_req, lock_req}));

    a_r12_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || erase_blk_req || erase_page_req) |=> !(prog_req || erase_blk_req || erase_page_req));

    // R5: no erase request into the boot range under lockout
    a_r5_boot_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_blk_req || erase_page_req) |-> !($past(lock_eff) && op_addr < BOOT_LIMIT));

    // R9: a read cycle returns the sequence to idle
    a_r9_read_abort: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cyc |=> state == ST_IDLE);

    // R11: busy freezes the sequence on a write
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && busy && !rd_cyc) |=> $stable(state) && $stable(id_active));

endmodule

// File: rtl/id_read_mux.sv
module id_read_mux #(
    parameter int          ADDR_W   = 18,
    parameter int          DATA_W   = 16,
    parameter logic [15:0] MFR_CODE = 16'h00DA,
    parameter logic [15:0] DEV_CODE = 16'h003D
) (
    input  logic              id_active,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              lock_set,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] id_word;

    always_comb begin
        unique case (addr)
            ADDR_W'(0): id_word = DATA_W'(MFR_CODE);
            ADDR_W'(1): id_word = DATA_W'(DEV_CODE);
            ADDR_W'(2): id_word = {{(DATA_W-1){1'b0}}, lock_set};
            default:    id_word = '0;
        endcase
    end

    assign rd_data = id_active ? id_word : arr_rdata;

    // R8: outside ID mode the array word passes through
    always_comb begin
        a_r8_passthru: assert (id_active || rd_data == arr_rdata);
    end

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder #(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int BOOT_WORDS = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              lock_set,
    input  logic              hv_override,
    input  logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              prog_req,
    output logic              erase_chip_req,
    output logic              erase_blk_req,
    output logic              erase_page_req,
    output logic              lock_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              chip_keep_boot,
    output logic              id_active
);

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              rd_cyc;

    bus_cycle_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_cyc(rd_cyc)
    );

    seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_WORDS(BOOT_WORDS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_cyc(rd_cyc), .lock_set(lock_set),
        .hv_override(hv_override), .busy(busy), .prog_req(prog_req),
        .erase_chip_req(erase_chip_req), .erase_blk_req(erase_blk_req),
        .erase_page_req(erase_page_req), .lock_req(lock_req),
        .op_addr(op_addr), .op_data(op_data),
        .chip_keep_boot(chip_keep_boot), .id_active(id_active)
    );

    id_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mux_i (
        .id_active(id_active), .addr(addr), .arr_rdata(arr_rdata),
        .lock_set(lock_set), .rd_data(rd_data)
    );

endmodule

// File: tb/unlock_cmd_decoder_tb_top.sv
module unlock_cmd_decoder_tb_top;

    localparam int AW = 18;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] arr_rdata = 16'hBEEF;
    logic          lock_set = 1'b0, hv_override = 1'b0, busy = 1'b0;
    logic [DW-1:0] rd_data;
    logic          prog_req, erase_chip_req, erase_blk_req, erase_page_req, lock_req;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic          chip_keep_boot, id_active;

    int checks = 0;
    int failures = 0;
    int n_prog = 0, n_chip = 0, n_blk = 0, n_page = 0, n_lock = 0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic          last_keep = 1'b0;

    always #2 clk = ~clk;

    unlock_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .arr_rdata(arr_rdata), .lock_set(lock_set),
        .hv_override(hv_override), .busy(busy), .rd_data(rd_data),
        .prog_req(prog_req), .erase_chip_req(erase_chip_req),
        .erase_blk_req(erase_blk_req), .erase_page_req(erase_page_req),
        .lock_req(lock_req), .op_addr(op_addr), .op_data(op_data),
        .chip_keep_boot(chip_keep_boot), .id_active(id_active)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_req)       begin n_prog++; last_addr = op_addr; last_data = op_data; end
            if (erase_chip_req) begin n_chip++; last_keep = chip_keep_boot; end
            if (erase_blk_req)  begin n_blk++;  last_addr = op_addr; end
            if (erase_page_req) begin n_page++; last_addr = op_addr; end
            if (lock_req)       n_lock++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write_x(input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input logic [AW-1:0] a_late, input logic ce, input logic oe);
        @(negedge clk); addr = a; ce_n = ce; oe_n = oe; we_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); addr = a_late; wdata = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_write_x(a, d, a, 1'b0, 1'b1);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); d = rd_data;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic unlock2();
        bus_write(18'h05555, 16'h00AA);
        bus_write(18'h02AAA, 16'h0055);
    endtask

    task automatic erase_prefix();
        unlock2();
        bus_write(18'h05555, 16'h0080);
        unlock2();
    endtask

    task automatic t_reset();
        check(prog_req == 0 && erase_chip_req == 0 && erase_blk_req == 0 &&
              erase_page_req == 0 && lock_req == 0, "R12 reset requests low", 0, 0);
        check(id_active == 0, "R7 reset id_active", id_active, 0);
        check(rd_data == arr_rdata, "R8 reset passthrough", rd_data, arr_rdata);
    endtask

    task automatic t_program();
        int p0 = n_prog;
        unlock2();
        bus_write(18'h05555, 16'h00A0);
        bus_write_x(18'h2A5C3, 16'h1234, 18'h00001, 1'b0, 1'b1);
        check(n_prog == p0 + 1, "R1 program issued", n_prog - p0, 1);
        check(last_addr == 18'h2A5C3, "R1 address from falling edge", last_addr, 18'h2A5C3);
        check(last_data == 16'h1234, "R1 data word", last_data, 16'h1234);
    endtask

    task automatic t_alias();
        int p0 = n_prog;
        bus_write(18'h15555, 16'hFFAA);
        bus_write(18'h3AAAA, 16'h7755);
        bus_write(18'h25555, 16'h12A0);
        bus_write(18'h3FFFF, 16'hCAFE);
        check(n_prog == p0 + 1, "R2 aliased magic match", n_prog - p0, 1);
        check(last_data == 16'hCAFE, "R2 target data", last_data, 16'hCAFE);
    endtask

    task automatic t_chip();
        int c0 = n_chip;
        lock_set = 1'b0;
        erase_prefix(); bus_write(18'h05555, 16'h0010);
        check(n_chip == c0 + 1, "R3 chip erase unlocked", n_chip - c0, 1);
        check(last_keep == 1'b0, "R3 keep_boot clear", last_keep, 0);
        lock_set = 1'b1;
        erase_prefix(); bus_write(18'h05555, 16'h0010);
        check(n_chip == c0 + 2, "R3 chip erase locked", n_chip - c0, 2);
        check(last_keep == 1'b1, "R3 keep_boot set", last_keep, 1);
        lock_set = 1'b0;
    endtask

    task automatic t_blk_page();
        int b0 = n_blk;
        int g0 = n_page;
        erase_prefix(); bus_write(18'h08000, 16'h0030);
        check(n_blk == b0 + 1 && last_addr == 18'h08000, "R4 block erase", last_addr, 18'h08000);
        erase_prefix(); bus_write(18'h01800, 16'h0050);
        check(n_page == g0 + 1 && last_addr == 18'h01800, "R4 page erase", last_addr, 18'h01800);
    endtask

    task automatic t_boot_lock();
        int b0 = n_blk;
        int g0 = n_page;
        lock_set = 1'b1;
        erase_prefix(); bus_write(18'h01FFF, 16'h0030);
        check(n_blk == b0, "R5 locked block in boot dropped", n_blk - b0, 0);
        erase_prefix(); bus_write(18'h00800, 16'h0050);
        check(n_page == g0, "R5 locked page in boot dropped", n_page - g0, 0);
        erase_prefix(); bus_write(18'h02000, 16'h0030);
        check(n_blk == b0 + 1 && last_addr == 18'h02000, "R5 block just above boot", last_addr, 18'h02000);
        hv_override = 1'b1;
        erase_prefix(); bus_write(18'h00800, 16'h0050);
        check(n_page == g0 + 1 && last_addr == 18'h00800, "R5 override allows boot page", last_addr, 18'h00800);
        hv_override = 1'b0;
        lock_set = 1'b0;
    endtask

    task automatic t_lock_en();
        int l0 = n_lock;
        erase_prefix(); bus_write(18'h05555, 16'h0040);
        check(n_lock == l0 + 1, "R6 lockout enable", n_lock - l0, 1);
    endtask

    task automatic t_id();
        logic [DW-1:0] d;
        unlock2(); bus_write(18'h05555, 16'h0090);
        check(id_active == 1, "R7 id entry", id_active, 1);
        bus_read(18'h00000, d); check(d == 16'h00DA, "R8 maker code", d, 16'h00DA);
        bus_read(18'h00001, d); check(d == 16'h003D, "R8 device code", d, 16'h003D);
        lock_set = 1'b1;
        bus_read(18'h00002, d); check(d == 16'h0001, "R8 lock bit", d, 1);
        lock_set = 1'b0;
        bus_read(18'h00002, d); check(d == 16'h0000, "R8 lock bit clear", d, 0);
        bus_write(18'h01234, 16'h00F0);
        check(id_active == 0, "R7 single-write exit", id_active, 0);
        bus_read(18'h00000, d); check(d == arr_rdata, "R8 passthrough after exit", d, arr_rdata);
        unlock2(); bus_write(18'h05555, 16'h0090);
        unlock2(); bus_write(18'h05555, 16'h00F0);
        check(id_active == 0, "R7 three-write exit", id_active, 0);
    endtask

    task automatic t_abort();
        logic [DW-1:0] d;
        int p0 = n_prog;
        unlock2(); bus_write(18'h05555, 16'h00A0);
        bus_read(18'h00010, d);
        bus_write(18'h00100, 16'h5A5A);
        check(n_prog == p0, "R9 read aborts program", n_prog - p0, 0);
        unlock2(); bus_write(18'h05555, 16'h00A1);
        bus_write(18'h00100, 16'h5A5A);
        check(n_prog == p0, "R9 mismatch aborts", n_prog - p0, 0);
    endtask

    task automatic t_gating();
        int p0 = n_prog;
        unlock2();
        bus_write_x(18'h05555, 16'h00A0, 18'h05555, 1'b1, 1'b1);
        bus_write(18'h05555, 16'h00A0);
        bus_write(18'h00200, 16'h0F0F);
        check(n_prog == p0 + 1 && last_addr == 18'h00200, "R10 ce high write ignored", n_prog - p0, 1);
        bus_write_x(18'h05555, 16'h00AA, 18'h05555, 1'b0, 1'b0);
        bus_write(18'h02AAA, 16'h0055);
        bus_write(18'h05555, 16'h00A0);
        bus_write(18'h00300, 16'h0F0F);
        check(n_prog == p0 + 1, "R10 oe low write ignored", n_prog - p0, 1);
    endtask

    task automatic t_busy();
        int p0 = n_prog;
        unlock2();
        busy = 1'b1;
        bus_write(18'h05555, 16'h0099);
        busy = 1'b0;
        bus_write(18'h05555, 16'h00A0);
        bus_write(18'h00400, 16'h4444);
        check(n_prog == p0 + 1 && last_addr == 18'h00400, "R11 busy write ignored", n_prog - p0, 1);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_program();
        t_alias();
        t_chip();
        t_blk_page();
        t_boot_lock();
        t_lock_en();
        t_id();
        t_abort();
        t_gating();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule